// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This peripheral keeps time as a single binary count of seconds. A reference enable arriving at 32768 Hz feeds a prescaler, and every 32768th enable yields a one-second tick that advances the count. Software uses a small 32-bit register bus with word offsets. It can read the running count and write a separate load register to replace the count. It can also program a match value that raises an alarm.

When a tick brings the count to the match value, a raw alarm flag is set. The flag stays set until software clears it by writing a one to the clear register. A mask register gates the flag onto the interrupt line. A separate masked-status view shows what is driving the interrupt, while the raw view can still be polled with the interrupt masked. A control bit can halt the count.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset the count, match, load, mask and raw alarm are all zero, `irq_o` is low and the run bit (control 0x0C bit 0) is one.
- R2: While running, the count at offset 0x00 rises by exactly one for every DIV reference enables. It wraps from all-ones to zero.
- R3: A write to offset 0x08 replaces the count with the written value and restarts the prescaler from zero. Offset 0x00 then returns that value, and counting resumes from it. Offset 0x08 reads back the last value written.
- R4: The match value at offset 0x04 is readable and writable.
- R5: Raw alarm (offset 0x14, bit 0) sets on the tick where the count becomes equal to the match value. It stays set after the count moves past the match value.
- R6: Writing 1 to bit 0 of offset 0x1C clears the raw alarm, and writing 0 has no effect. If a set and a clear fall in the same cycle, the flag ends up set.
- R7: The mask is bit 0 of offset 0x10. Masked status (offset 0x18, bit 0) equals raw AND mask. `irq_o` is high exactly when that bit is set. The raw alarm reads back even while the mask is zero.
- R8: With the run bit at zero, reference enables do not change the count.
- R9: Reads of offset 0x1C and of unmapped offsets return zero. Writes to offsets 0x00, 0x14 and 0x18 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | 32768 Hz reference enable, one clock wide per pulse |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | AW (8) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| irq_o | output | 1 | Alarm interrupt |

## Verification
Two functions can fall in the same cycle: the comparator setting the raw alarm, and a software write of 1 to the clear register. The bench provokes this by running the prescaler up to one enable short of the matching second. It then issues the clear write in the same clock as the final enable. The raw flag must read back as set afterwards. A second collision loads the count in the same cycle as a tick, and the loaded value must win over the increment.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned WORD_COUNT  = 3'd0;
  localparam int unsigned WORD_MATCH  = 3'd1;
  localparam int unsigned WORD_LOAD   = 3'd2;
  localparam int unsigned WORD_CTRL   = 3'd3;
  localparam int unsigned WORD_MASK   = 3'd4;
  localparam int unsigned WORD_RAW    = 3'd5;
  localparam int unsigned WORD_MASKED = 3'd6;
  localparam int unsigned WORD_CLEAR  = 3'd7;

  // Next seconds value: plain modular increment.
  function automatic logic [31:0] sec_next(input logic [31:0] cur);
    return cur + 32'd1;
  endfunction

  // Alarm condition on the value the count is about to take.
  function automatic logic alarm_hit(input logic [31:0] nxt, input logic [31:0] match);
    return nxt == match;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic restart,
  output logic sec_tick
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign sec_tick = ref_tick && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase <= '0;
    else if (restart)    phase <= '0;
    else if (sec_tick)   phase <= '0;
    else if (ref_tick)   phase <= phase + 1'b1;
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] match_val,
  output logic [CW-1:0] count,
  output logic          match_evt
);
  import rtc_pkg::*;

  logic [CW-1:0] count_inc;

  assign count_inc = CW'(sec_next(32'(count)));
  assign match_evt = advance && !load_en && alarm_hit(32'(count_inc), 32'(match_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load_en) count <= load_val;
    else if (advance) count <= count_inc;
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic match_evt,
  input  logic clr_hit,
  input  logic mask_wr,
  input  logic mask_val,
  output logic raw,
  output logic mask,
  output logic masked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         raw <= 1'b0;
    else if (match_evt) raw <= 1'b1;
    else if (clr_hit)   raw <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= 1'b0;
    else if (mask_wr) mask <= mask_val;
  end

  assign masked = raw & mask;
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm #(
  parameter int unsigned DIV = 32768,
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_o
);
  import rtc_pkg::*;

  localparam int unsigned WW = AW - 2;

  logic [WW-1:0] word;
  logic          wr_en, rd_en;
  logic          load_wr, match_wr, ctrl_wr, mask_wr, clr_hit;
  logic          sec_tick, advance, match_evt;
  logic [CW-1:0] count, match_q, load_q;
  logic          run_q, raw, mask, masked;
  logic          unused_bits;

  assign word     = bus_addr[AW-1:2];
  assign wr_en    = bus_sel && bus_wr;
  assign rd_en    = bus_sel && !bus_wr;
  assign load_wr  = wr_en && (word == WW'(WORD_LOAD));
  assign match_wr = wr_en && (word == WW'(WORD_MATCH));
  assign ctrl_wr  = wr_en && (word == WW'(WORD_CTRL));
  assign mask_wr  = wr_en && (word == WW'(WORD_MASK));
  assign clr_hit  = wr_en && (word == WW'(WORD_CLEAR)) && bus_wdata[0];
  assign advance  = sec_tick && run_q;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  rtc_prescaler #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .restart(load_wr), .sec_tick(sec_tick)
  );

  rtc_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .advance(advance), .load_en(load_wr),
    .load_val(bus_wdata[CW-1:0]), .match_val(match_q),
    .count(count), .match_evt(match_evt)
  );

  rtc_alarm_irq u_irq (
    .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .clr_hit(clr_hit),
    .mask_wr(mask_wr), .mask_val(bus_wdata[0]),
    .raw(raw), .mask(mask), .masked(masked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      load_q  <= '0;
      run_q   <= 1'b1;
    end else begin
      if (match_wr) match_q <= bus_wdata[CW-1:0];
      if (load_wr)  load_q  <= bus_wdata[CW-1:0];
      if (ctrl_wr)  run_q   <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (word == WW'(WORD_COUNT))       bus_rdata = 32'(count);
      else if (word == WW'(WORD_MATCH))  bus_rdata = 32'(match_q);
      else if (word == WW'(WORD_LOAD))   bus_rdata = 32'(load_q);
      else if (word == WW'(WORD_CTRL))   bus_rdata = {31'd0, run_q};
      else if (word == WW'(WORD_MASK))   bus_rdata = {31'd0, mask};
      else if (word == WW'(WORD_RAW))    bus_rdata = {31'd0, raw};
      else if (word == WW'(WORD_MASKED)) bus_rdata = {31'd0, masked};
    end
  end

  assign irq_o = masked;
endmodule

// File: rtl/rtc_seconds_alarm_sva.sv
module rtc_seconds_alarm_sva #(
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          advance,
  input logic          load_wr,
  input logic          match_evt,
  input logic          clr_hit,
  input logic [31:0]   bus_wdata,
  input logic [CW-1:0] count,
  input logic          raw,
  input logic          mask,
  input logic          irq_o
);
  assert_alarm_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> raw);
  assert_alarm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !clr_hit) |=> raw);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !match_evt) |=> !raw);
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (count == $past(bus_wdata[CW-1:0])));
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load_wr) |=> (count == CW'($past(count) + 1'b1)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load_wr) |=> $stable(count));
  assert_irq_needs_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raw && mask));
  assert_irq_when_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && mask) |-> irq_o);
endmodule

bind rtc_seconds_alarm rtc_seconds_alarm_sva #(.CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .advance(advance), .load_wr(load_wr),
  .match_evt(match_evt), .clr_hit(clr_hit), .bus_wdata(bus_wdata),
  .count(count), .raw(raw), .mask(mask), .irq_o(irq_o)
);

// File: tb/rtc_seconds_alarm_tb.sv
module rtc_seconds_alarm_tb;
  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] exp;
    bit          is_irq;
    string       tag;
  } item_t;
  item_t exp_q[$];
  bit    pend = 1'b0;

  always #2.5 clk = ~clk;

  rtc_seconds_alarm #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Monitor: pops the expected item and compares it mid-cycle.
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      act = it.is_irq ? {31'd0, irq_o} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_read(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back('{e, 1'b0, tag});
    pend = 1'b1;
    @(posedge clk); #1;
    bus_sel = 1'b0; pend = 1'b0;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    @(posedge clk); #1;
    exp_q.push_back('{{31'd0, e}, 1'b1, tag});
    pend = 1'b1;
    @(posedge clk); #1;
    pend = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    if (n > 0) begin
      @(posedge clk); #1;
      ref_tick = 1'b1;
      repeat (n) @(posedge clk);
      #1 ref_tick = 1'b0;
    end
  endtask

  // Reference enable and a bus write in the same clock.
  task automatic tick_with_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    ref_tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    ref_tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_read(8'h00, 32'd0, "R1 count");
    expect_read(8'h04, 32'd0, "R1 match");
    expect_read(8'h08, 32'd0, "R1 load");
    expect_read(8'h0C, 32'd1, "R1 run bit");
    expect_read(8'h10, 32'd0, "R1 mask");
    expect_read(8'h14, 32'd0, "R1 raw");
    expect_irq(1'b0, "R1 irq");

    // R2 prescaler and counting
    run_ticks(DIV * 3);
    expect_read(8'h00, 32'd3, "R2 three seconds");
    run_ticks(DIV - 1);
    expect_read(8'h00, 32'd3, "R2 partial second");
    run_ticks(1);
    expect_read(8'h00, 32'd4, "R2 second completes");

    // R3 load
    run_ticks(2);
    bus_write(8'h08, 32'd100);
    expect_read(8'h00, 32'd100, "R3 loaded count");
    expect_read(8'h08, 32'd100, "R3 load readback");
    run_ticks(DIV * 2);
    expect_read(8'h00, 32'd102, "R3 counts from load");
    // R3 load colliding with a tick: load wins
    run_ticks(DIV - 1);
    tick_with_write(8'h08, 32'd500);
    expect_read(8'h00, 32'd500, "R3 load beats tick");
    run_ticks(DIV);
    expect_read(8'h00, 32'd501, "R3 prescaler restarted");

    // R9 read-only writes ignored, unmapped reads zero
    bus_write(8'h00, 32'h55);
    bus_write(8'h14, 32'h1);
    bus_write(8'h18, 32'h1);
    expect_read(8'h00, 32'd501, "R9 write to count ignored");
    expect_read(8'h14, 32'd0, "R9 write to raw ignored");
    expect_read(8'h18, 32'd0, "R9 write to masked ignored");
    expect_read(8'h20, 32'd0, "R9 unmapped read");
    expect_read(8'h1C, 32'd0, "R9 clear reads zero");

    // R4 match, R5 alarm
    bus_write(8'h08, 32'd103);
    bus_write(8'h04, 32'd105);
    expect_read(8'h04, 32'd105, "R4 match readback");
    run_ticks(DIV);
    expect_read(8'h14, 32'd0, "R5 no alarm before match");
    run_ticks(DIV);
    expect_read(8'h00, 32'd105, "R5 count at match");
    expect_read(8'h14, 32'd1, "R5 raw set, R7 visible while masked");
    expect_read(8'h18, 32'd0, "R7 masked status low");
    expect_irq(1'b0, "R7 irq low when masked");
    run_ticks(DIV);
    expect_read(8'h14, 32'd1, "R5 sticky past match");

    // R7 mask
    bus_write(8'h10, 32'd1);
    expect_read(8'h18, 32'd1, "R7 masked status high");
    expect_irq(1'b1, "R7 irq high");
    bus_write(8'h10, 32'd0);
    expect_irq(1'b0, "R7 irq drops on mask clear");
    bus_write(8'h10, 32'd1);

    // R6 clear
    bus_write(8'h1C, 32'd0);
    expect_read(8'h14, 32'd1, "R6 writing zero keeps flag");
    bus_write(8'h1C, 32'd1);
    expect_read(8'h14, 32'd0, "R6 clear");
    expect_irq(1'b0, "R6 irq after clear");

    // R6 set and clear in the same cycle
    bus_write(8'h08, 32'd200);
    bus_write(8'h04, 32'd201);
    run_ticks(DIV - 1);
    tick_with_write(8'h1C, 32'd1);
    expect_read(8'h00, 32'd201, "R6 collision count");
    expect_read(8'h14, 32'd1, "R6 set wins over clear");
    expect_irq(1'b1, "R6 irq after collision");
    bus_write(8'h1C, 32'd1);

    // R8 run control
    bus_write(8'h0C, 32'd0);
    expect_read(8'h0C, 32'd0, "R8 run bit cleared");
    run_ticks(DIV * 2);
    expect_read(8'h00, 32'd201, "R8 halted count");
    bus_write(8'h0C, 32'd1);

    // R2 wrap
    bus_write(8'h08, 32'hFFFF_FFFF);
    run_ticks(DIV);
    expect_read(8'h00, 32'd0, "R2 wrap to zero");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule